// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without taking part in it. It samples SCL and SDA through synchronizers and recognises START, repeated START and STOP. It shifts in the address byte that follows each START and compares the address with four programmable 7-bit entries. A match-all option accepts any address instead. Once an address matches, the block captures every following byte in either direction until the next START or STOP, and raises an interrupt for each byte. Bytes from a master read are the bytes the addressed slave actually drove.

The block has no SDA output, so it can never acknowledge a byte or take part in arbitration. After every ninth bit, the data byte is copied into a read-only holding register. Software then has nine bit-times to fetch it, even when the bus is never stalled. An optional stretch output can pull SCL low after a captured byte until software clears the interrupt. Software reaches the block through a small register port: a write strobe, an address, and write and read data buses.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A START or repeated START (SDA falling while SCL is high) begins a new address byte. A STOP (SDA rising while SCL is high) ends the transfer and clears the matched state (STATUS bit 2). No further byte interrupts occur until a new address matches.
- R2: The upper seven bits of the address byte are compared with four 7-bit entries, held at register offsets 4 to 7 in bits [6:0]. On a match, the interrupt is raised after the ninth bit of the address byte.
- R3: When no entry matches and match-all is off, neither the address byte nor the data bytes that follow raise an interrupt.
- R4: With match-all (CTRL bit 2) set and monitor enable (CTRL bit 0) set, every address counts as a match.
- R5: While monitor enable is 0, the match-all and stretch-enable (CTRL bit 1) settings have no effect.
- R6: After a match, each data byte of a master write raises the interrupt and appears in the holding register (offset 2).
- R7: Bit 0 of the address byte is latched into STATUS bit 1 as the direction. In a read transfer, the bytes driven by the addressed slave are captured and interrupt like written bytes.
- R8: After every ninth bit of any transfer, matched or not, the holding register is loaded with that frame's eight data bits. It changes at no other time. Offset 3 reads the upper eight bits of the live 9-bit shift register.
- R9: With stretch enabled, `scl_hold_o` goes high after the ninth bit's SCL falling edge while the interrupt is pending, and drops once the interrupt is cleared. With stretch disabled, it never goes high.
- R10: STATUS is at offset 1. Bit 0 is the pending interrupt, which a write with bit 0 set clears. Bit 3 shows SCL being held. CTRL is at offset 0. `irq_o` follows STATUS bit 0.
- R11: After reset, the interrupt, the hold output, STATUS, CTRL and the holding register all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_hold_o | output | 1 | Pull SCL low while high (open-drain control) |
| irq_o | output | 1 | Byte-captured interrupt |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | $clog2(4+NUM_ADDR) | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The bench builds the block with four address entries, so all four compare paths, the match-all path and a non-matching address can be reached. It uses three synchronizer stages instead of the default two. This shows that the extra input latency leaves byte capture, repeated-START handling and the release of SCL after the interrupt is cleared unchanged. A bus model that combines the master's clock with `scl_hold_o` lets the bench watch the stretch begin after the ninth falling edge and end on the clearing write.

// File: rtl/i2c_mon_pkg.sv
`timescale 1ns/1ps
package i2c_mon_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP,
        ST_ARM,
        ST_STRETCH
    } mon_state_t;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned FRAME_BITS = 9;

    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_STAT  = 1;
    localparam int unsigned OFS_HOLD  = 2;
    localparam int unsigned OFS_SHIFT = 3;
    localparam int unsigned OFS_ADDR0 = 4;

    localparam int unsigned CTRL_MON = 0;
    localparam int unsigned CTRL_STR = 1;
    localparam int unsigned CTRL_ALL = 2;
endpackage

// File: rtl/i2c_mon_sync.sv
`timescale 1ns/1ps
module i2c_mon_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
`timescale 1ns/1ps
module i2c_mon_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_mon_match.sv
`timescale 1ns/1ps
module i2c_mon_match #(
    parameter int NUM_ADDR = 4
) (
    input  logic [NUM_ADDR-1:0][6:0] addr_tbl,
    input  logic [6:0]               cand,
    input  logic                     match_all,
    output logic                     hit
);
    logic [NUM_ADDR-1:0] hit_vec;

    generate
        for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
            assign hit_vec[i] = (addr_tbl[i] == cand);
        end
    endgenerate

    assign hit = match_all | (|hit_vec);
endmodule

// File: rtl/i2c_mon_fsm.sv
`timescale 1ns/1ps
module i2c_mon_fsm import i2c_mon_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda,
    input  logic              addr_hit,
    input  logic              stretch_en,
    input  logic              irq_pending,
    output logic [6:0]        cand,
    output logic              byte_done,
    output logic              irq_set,
    output logic [BYTE_W-1:0] hold_byte,
    output logic [BYTE_W-1:0] shift_view,
    output logic              dir,
    output logic              matched,
    output logic              scl_hold
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    mon_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W:0]   sh_q;
    logic [BYTE_W:0]   sh_next;
    logic              shift_en;
    logic              frame_end;

    assign sh_next   = {sh_q[BYTE_W-1:0], sda};
    assign shift_en  = scl_rise && (state_q != ST_IDLE);
    assign frame_end = shift_en && (bit_cnt_q == CNT_W'(FRAME_BITS - 1));
    assign cand      = sh_next[BYTE_W:2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR:
                    if (frame_end)
                        state_d = !addr_hit ? ST_SKIP :
                                  (stretch_en ? ST_ARM : ST_DATA);
                ST_DATA:
                    if (frame_end && stretch_en) state_d = ST_ARM;
                ST_SKIP: ;
                ST_ARM:
                    if (!irq_pending || !stretch_en) state_d = ST_DATA;
                    else if (scl_fall)               state_d = ST_STRETCH;
                ST_STRETCH:
                    if (!irq_pending || !stretch_en) state_d = ST_DATA;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // bit counter, shift register, holding buffer, direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            sh_q      <= '0;
            hold_byte <= '0;
            dir       <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt_q <= '0;
        end else if (shift_en) begin
            sh_q      <= sh_next;
            bit_cnt_q <= frame_end ? '0 : bit_cnt_q + 1'b1;
            if (frame_end) hold_byte <= sh_next[BYTE_W:1];
            if (frame_end && state_q == ST_ADDR) dir <= sh_next[1];
        end
    end

    // outputs
    always_comb begin
        byte_done  = frame_end;
        irq_set    = frame_end && (((state_q == ST_ADDR) && addr_hit) ||
                                   (state_q == ST_DATA));
        shift_view = sh_q[BYTE_W:1];
        matched    = (state_q == ST_DATA) || (state_q == ST_ARM) ||
                     (state_q == ST_STRETCH);
        scl_hold   = (state_q == ST_STRETCH) && stretch_en && irq_pending;
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
`timescale 1ns/1ps
module i2c_bus_monitor import i2c_mon_pkg::*; #(
    parameter  int NUM_ADDR    = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(OFS_ADDR0 + NUM_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_hold_o,
    output logic              irq_o,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o
);
    logic [2:0]                     ctrl_q;
    logic [NUM_ADDR-1:0][BYTE_W-1:0] addr_tbl_q;
    logic [NUM_ADDR-1:0][6:0]       addr7;
    logic                           irq_q;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic mon_en, eff_stretch, eff_all;
    logic addr_hit, byte_done, irq_set, dir, matched;
    logic [6:0]        cand;
    logic [BYTE_W-1:0] hold_byte, shift_view;

    assign mon_en      = ctrl_q[CTRL_MON];
    assign eff_stretch = mon_en & ctrl_q[CTRL_STR];
    assign eff_all     = mon_en & ctrl_q[CTRL_ALL];

    i2c_mon_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    i2c_mon_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    generate
        for (genvar i = 0; i < NUM_ADDR; i++) begin : g_tbl
            assign addr7[i] = addr_tbl_q[i][6:0];
        end
    endgenerate

    i2c_mon_match #(.NUM_ADDR(NUM_ADDR)) u_match (
        .addr_tbl(addr7), .cand(cand), .match_all(eff_all), .hit(addr_hit)
    );

    i2c_mon_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda(sda_s),
        .addr_hit(addr_hit), .stretch_en(eff_stretch), .irq_pending(irq_q),
        .cand(cand), .byte_done(byte_done), .irq_set(irq_set),
        .hold_byte(hold_byte), .shift_view(shift_view), .dir(dir),
        .matched(matched), .scl_hold(scl_hold_o)
    );

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            addr_tbl_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == AW'(OFS_CTRL)) ctrl_q <= reg_wdata_i[2:0];
            for (int i = 0; i < NUM_ADDR; i++) begin
                if (reg_addr_i == AW'(OFS_ADDR0 + i)) addr_tbl_q[i] <= reg_wdata_i;
            end
        end
    end

    // interrupt flag: a captured byte wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (reg_wr_i && reg_addr_i == AW'(OFS_STAT) && reg_wdata_i[0])
            irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // register reads
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == AW'(OFS_CTRL))  reg_rdata_o = {5'b0, ctrl_q};
        if (reg_addr_i == AW'(OFS_STAT))  reg_rdata_o = {4'b0, scl_hold_o, matched, dir, irq_q};
        if (reg_addr_i == AW'(OFS_HOLD))  reg_rdata_o = hold_byte;
        if (reg_addr_i == AW'(OFS_SHIFT)) reg_rdata_o = shift_view;
        for (int i = 0; i < NUM_ADDR; i++) begin
            if (reg_addr_i == AW'(OFS_ADDR0 + i)) reg_rdata_o = addr_tbl_q[i];
        end
    end
endmodule

// File: rtl/i2c_mon_checker.sv
`timescale 1ns/1ps
module i2c_mon_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_done,
    input logic       scl_fall,
    input logic       stop_det,
    input logic       matched,
    input logic       irq_o,
    input logic       scl_hold_o,
    input logic       mon_en,
    input logic [7:0] hold_byte
);
    // R6: the interrupt only rises in the cycle after a completed frame
    assert_irq_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(byte_done));

    // R1: a STOP leaves the block unmatched
    assert_stop_unmatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !matched);

    // R8: the holding register moves only on a frame end
    assert_buffer_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(hold_byte));

    // R9: a stretch only begins right after a seen SCL falling edge
    assert_hold_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> $past(scl_fall));

    // R5: with monitoring off SCL is never held
    assert_no_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |-> !scl_hold_o);
endmodule

bind i2c_bus_monitor i2c_mon_checker u_checker (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .scl_fall(scl_fall),
    .stop_det(stop_det), .matched(matched), .irq_o(irq_o),
    .scl_hold_o(scl_hold_o), .mon_en(mon_en), .hold_byte(hold_byte)
);

// File: tb/tb_i2c_bus_monitor.sv
`timescale 1ns/1ps
module tb_i2c_bus_monitor;
    localparam int NA = 4;
    localparam int AW = $clog2(4 + NA);
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_hold, irq;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    wire scl_bus = scl_m & ~scl_hold;

    int checks = 0, fails = 0;
    bit finished = 0;

    i2c_bus_monitor #(.NUM_ADDR(NA), .SYNC_STAGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_m),
        .scl_hold_o(scl_hold), .irq_o(irq),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(int a, logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_read(int a, output logic [7:0] d);
        @(negedge clk); addr = AW'(a); #1; d = rdata;
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half(); scl_m = 1'b1; half();
        sda_m = 1'b0; half(); scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
    endtask

    task automatic send_bit(logic b);
        sda_m = b; half();
        scl_m = 1'b1;
        while (scl_hold) @(negedge clk);
        half();
        scl_m = 1'b0; half();
    endtask

    task automatic send_byte(logic [7:0] b, logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ack);
    endtask

    task automatic clear_irq();
        reg_write(1, 8'h01);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R11", "irq after reset", irq, 0);
        check("R11", "hold after reset", scl_hold, 0);
        reg_read(1, v); check("R11", "status after reset", v, 0);
        reg_read(0, v); check("R11", "ctrl after reset", v, 0);
        reg_read(2, v); check("R11", "buffer after reset", v, 0);
    endtask

    task automatic t_write_match();
        logic [7:0] v;
        bus_start();
        send_byte(8'h68, 1'b0);                        // address 0x34, write
        check("R2", "irq on address match", irq, 1);
        reg_read(1, v); check("R10", "status after match", v, 8'h05);
        reg_read(2, v); check("R8", "buffer holds address", v, 8'h68);
        clear_irq();
        check("R10", "irq cleared by write", irq, 0);
        send_byte(8'hA5, 1'b0);
        check("R6", "irq on data byte 1", irq, 1);
        reg_read(2, v); check("R6", "buffer data byte 1", v, 8'hA5);
        clear_irq();
        send_byte(8'h3C, 1'b0);
        check("R6", "irq on data byte 2", irq, 1);
        reg_read(2, v); check("R6", "buffer data byte 2", v, 8'h3C);
        clear_irq();
        bus_stop();
        reg_read(1, v); check("R1", "status after stop", v, 8'h00);
    endtask

    task automatic t_read_dir();
        logic [7:0] v;
        bus_start();
        send_byte(8'hA1, 1'b0);                        // address 0x50, read
        reg_read(1, v); check("R7", "status read direction", v, 8'h07);
        clear_irq();
        send_byte(8'hC3, 1'b1);                        // slave byte, master NACK
        check("R7", "irq on slave byte", irq, 1);
        reg_read(2, v); check("R7", "slave byte captured", v, 8'hC3);
        clear_irq();
        bus_stop();
    endtask

    task automatic t_nomatch();
        logic [7:0] v;
        bus_start();
        send_byte(8'h44, 1'b0);                        // address 0x22 not listed
        check("R3", "no irq on foreign address", irq, 0);
        reg_read(2, v); check("R8", "buffer loads unmatched address", v, 8'h44);
        send_byte(8'h99, 1'b0);
        check("R3", "no irq on foreign data", irq, 0);
        reg_read(2, v); check("R8", "buffer loads unmatched data", v, 8'h99);
        reg_read(3, v); check("R8", "shift view upper bits", v, 8'h99);
        bus_stop();
    endtask

    task automatic t_restart();
        logic [7:0] v;
        bus_start();
        send_byte(8'h24, 1'b0);                        // address 0x12
        check("R1", "match before repeated start", irq, 1);
        clear_irq();
        bus_start();                                   // repeated START
        send_byte(8'h44, 1'b0);
        check("R1", "no irq after restart to foreign", irq, 0);
        reg_read(1, v); check("R1", "unmatched after restart", v, 8'h00);
        send_byte(8'h55, 1'b0);
        check("R1", "no data irq after restart", irq, 0);
        bus_stop();
    endtask

    task automatic t_match_all();
        logic [7:0] v;
        reg_write(0, 8'h05);
        bus_start();
        send_byte(8'h1D, 1'b0);                        // address 0x0E, read
        check("R4", "match-all accepts any address", irq, 1);
        reg_read(1, v); check("R4", "status under match-all", v, 8'h07);
        clear_irq();
        bus_stop();
    endtask

    task automatic t_mon_off();
        reg_write(0, 8'h06);                           // stretch+all, monitor off
        bus_start();
        send_byte(8'h1D, 1'b0);
        check("R5", "match-all ignored when off", irq, 0);
        bus_start();
        send_byte(8'h24, 1'b0);
        check("R5", "listed address still matches", irq, 1);
        check("R5", "no stretch when off", scl_hold, 0);
        clear_irq();
        bus_stop();
    endtask

    task automatic t_stretch();
        logic [7:0] v;
        reg_write(0, 8'h03);
        bus_start();
        send_byte(8'hFE, 1'b0);                        // address 0x7F
        check("R9", "hold after ninth fall", scl_hold, 1);
        reg_read(1, v); check("R10", "status while holding", v, 8'h0D);
        repeat (20) @(negedge clk);
        check("R9", "hold persists while pending", scl_hold, 1);
        clear_irq();
        check("R9", "hold released on clear", scl_hold, 0);
        send_byte(8'h5A, 1'b0);
        check("R9", "hold on data byte", scl_hold, 1);
        reg_read(2, v); check("R9", "byte under stretch", v, 8'h5A);
        clear_irq();
        check("R9", "released after data clear", scl_hold, 0);
        bus_stop();
        reg_write(0, 8'h01);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        reg_write(0, 8'h01);
        reg_write(4, 8'h12);
        reg_write(5, 8'h34);
        reg_write(6, 8'h50);
        reg_write(7, 8'h7F);
        t_write_match();
        t_read_dir();
        t_nomatch();
        t_restart();
        t_match_all();
        t_mon_off();
        t_stretch();
        finish_run();
    end
endmodule